// File: doc/BRIEF.md
# Block Cipher Coprocessor Command Sequencer

This block is the control front end of a 128-bit block-cipher coprocessor. It sits on a CPU register bus and is fed by two DMA channels. The CPU writes a command byte into a control register. The command either loads a key, loads an IV/nonce, or starts one block operation. Each block needs its own start command.

Data enters one byte at a time through a data-in register and leaves through a data-out register. For the block modes a whole 128-bit block is collected, handed to a separate chaining datapath, and read back. For the stream modes (CFB, OFB, CTR) the block is exchanged as four 32-bit segments. Each segment is collected, processed and read out before the next one starts, and each segment has its own DMA triggers.

A completion flag and an interrupt request, gated by an enable bit, signal the end of a block. A key or IV load command aborts any block in flight. The key and IV are cleared by reset and by the power-down input.

Top module: `cipher_cmd_seq`

## Requirements
- R1: After reset the control read value is 0, the key and IV outputs are 0, and no strobe (`dma_in_req`, `dma_out_req`, `cph_req`, `cph_abort`, `irq`) is high.
- R2: A control write with command bits [1:0]=01 (start) while idle latches mode bits [4:2] and decrypt bit [5]. In the next cycle it raises busy (read bit 0) and pulses `dma_in_req` for one cycle.
- R3: In a block mode (mode not 2, 3 or 4), 16 data-in bytes are assembled with the first byte at the most significant end. One cycle after the 16th byte, `cph_req` pulses with `cph_op`=0 and `cph_data` holding the block.
- R4: When `cph_rsp_valid` arrives for a pending request, `dma_out_req` pulses in the next cycle. The result then appears on `dout_rdata` most significant byte first, advancing by one byte per `dout_re`. One cycle after the last byte is read, the block returns to idle.
- R5: In modes 2, 3 and 4 (CFB, OFB, CTR) the block is handled as four segments of 4 bytes each, with `cph_seg` counting 0 to 3. For each segment, `dma_in_req` pulses, `cph_data` carries the 32-bit segment zero-extended, and the low 32 response bits are read out as 4 bytes.
- R6: The completion flag (read bit 7, `done_flag`) sets on the response to the last unit of a block. It clears only on a control write with bit 7=0. When a set and a clear fall in the same cycle, the set wins. `irq` equals the flag ANDed with enable bit [6].
- R7: A start command received while busy is ignored: no `dma_in_req` and no change to the block in progress.
- R8: Command 10 loads a key and command 11 loads an IV; command 11 also latches the mode field. Either command pulses `dma_in_req`. After 16 bytes, `cph_key` or `cph_iv` takes the value, and `cph_req` pulses with `cph_op` 1 (key) or 2 (IV).
- R9: A key or IV command issued during a block pulses `cph_abort`. Any later response for that block is dropped: no `dma_out_req` and no completion flag.
- R10: `pwr_down` clears the key and IV to 0 and returns the sequencer to idle in the next cycle.
- R11: Data-in writes are ignored while a request is pending, and data-out reads are ignored outside the read-out phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_down | input | 1 | Deep low-power entry; clears key and IV |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write: [7] flag keep, [6] irq enable, [5] decrypt, [4:2] mode, [1:0] command |
| ctl_rdata | output | 8 | Status: [7] done, [6] enable, [5] decrypt, [4:2] mode, [0] busy |
| din_we | input | 1 | Data-in write strobe |
| din_wdata | input | 8 | Data-in byte |
| dout_re | input | 1 | Data-out read strobe (pops one byte) |
| dout_rdata | output | 8 | Current data-out byte |
| dma_in_req | output | 1 | Input channel trigger pulse |
| dma_out_req | output | 1 | Output channel trigger pulse |
| done_flag | output | 1 | Completion flag |
| irq | output | 1 | Interrupt request |
| cph_req | output | 1 | Request pulse to chaining datapath |
| cph_op | output | 2 | Request kind: 0 block, 1 key, 2 IV |
| cph_seg | output | 2 | Segment index in stream modes |
| cph_mode | output | 3 | Active mode |
| cph_dec | output | 1 | Active direction (1 = decrypt) |
| cph_data | output | 128 | Assembled block or zero-extended segment |
| cph_key | output | 128 | Key register |
| cph_iv | output | 128 | IV/nonce register |
| cph_abort | output | 1 | Abort pulse to datapath |
| cph_rsp_valid | input | 1 | Datapath result valid |
| cph_rsp_data | input | 128 | Datapath result |

## Verification
The completion flag can be set by the datapath response in the same cycle as a CPU control write that asks to clear it. The bench provokes this by driving `cph_rsp_valid` and a control write with bit 7 low on the same clock edge. When that response belongs to the last unit of a block, the flag is judged correct only if it reads 1 afterwards. When the response belongs to a middle stream segment, the flag is judged correct only if it reads 0. The same collision also arises between a response and an abort command, and there the response must leave no trace at the outputs.

// File: rtl/cseq_pkg.sv
package cseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD_KEY,
    ST_LOAD_IV,
    ST_FILL,
    ST_PROCESS,
    ST_DRAIN
  } seq_state_e;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_START = 2'd1,
    CMD_KEY   = 2'd2,
    CMD_IV    = 2'd3
  } cmd_e;

  localparam logic [1:0] OP_BLK = 2'd0;
  localparam logic [1:0] OP_KEY = 2'd1;
  localparam logic [1:0] OP_IV  = 2'd2;

  localparam logic [2:0] MODE_CFB = 3'd2;
  localparam logic [2:0] MODE_OFB = 3'd3;
  localparam logic [2:0] MODE_CTR = 3'd4;

  // Stream modes exchange data in segments rather than whole blocks
  function automatic logic is_stream(input logic [2:0] m);
    return (m == MODE_CFB) || (m == MODE_OFB) || (m == MODE_CTR);
  endfunction

endpackage

// File: rtl/cseq_ctl_reg.sv
module cseq_ctl_reg
  import cseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [7:0] wdata,
  input  logic       done_set,
  input  logic       busy,
  output cmd_e       cmd,
  output logic [2:0] wmode,
  output logic       wdec,
  output logic       done_q,
  output logic       irq_q,
  output logic [7:0] rdata
);

  logic       ie_q;
  logic       dec_q;
  logic [2:0] mode_q;
  logic       done_d;
  logic       ie_d;

  assign cmd   = we ? cmd_e'(wdata[1:0]) : CMD_NONE;
  assign wmode = wdata[4:2];
  assign wdec  = wdata[5];

  // A completion in the same cycle outranks a CPU clear
  always_comb begin
    done_d = done_q;
    if (done_set)
      done_d = 1'b1;
    else if (we && !wdata[7])
      done_d = 1'b0;
    ie_d = we ? wdata[6] : ie_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      ie_q   <= 1'b0;
      dec_q  <= 1'b0;
      mode_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      ie_q   <= ie_d;
      irq_q  <= done_d & ie_d;
      if (we) begin
        dec_q  <= wdata[5];
        mode_q <= wdata[4:2];
      end
    end
  end

  assign rdata = {done_q, ie_q, dec_q, mode_q, 1'b0, busy};

endmodule

// File: rtl/cseq_in_shift.sv
module cseq_in_shift #(
  parameter int DW    = 8,
  parameter int BYTES = 16,
  parameter int CW    = $clog2(BYTES + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic                  en,
  input  logic                  we,
  input  logic [DW-1:0]         din,
  input  logic [CW-1:0]         unit,
  output logic [DW*BYTES-1:0]   data,
  output logic                  full
);

  localparam int W = DW * BYTES;

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  shreg_q;

  assign full = (cnt_q == unit);
  assign data = shreg_q;

  // First byte written ends at the most significant end
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q   <= '0;
      shreg_q <= '0;
    end else if (en && we && !full) begin
      shreg_q <= {shreg_q[W-DW-1:0], din};
      cnt_q   <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/cseq_out_shift.sv
module cseq_out_shift #(
  parameter int DW    = 8,
  parameter int BYTES = 16,
  parameter int CW    = $clog2(BYTES + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [DW*BYTES-1:0] ldata,
  input  logic                en,
  input  logic                pop,
  input  logic [CW-1:0]       unit,
  output logic [DW-1:0]       dout,
  output logic                empty
);

  localparam int W = DW * BYTES;

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  shreg_q;

  assign empty = (cnt_q == unit);
  assign dout  = shreg_q[W-1 -: DW];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      shreg_q <= '0;
    end else if (load) begin
      cnt_q   <= '0;
      shreg_q <= ldata;
    end else if (en && pop && !empty) begin
      shreg_q <= {shreg_q[W-DW-1:0], {DW{1'b0}}};
      cnt_q   <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/cipher_cmd_seq.sv
module cipher_cmd_seq
  import cseq_pkg::*;
#(
  parameter int DW        = 8,
  parameter int BLK_BYTES = 16,
  parameter int SEG_BYTES = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       pwr_down,
  input  logic                       ctl_we,
  input  logic [7:0]                 ctl_wdata,
  output logic [7:0]                 ctl_rdata,
  input  logic                       din_we,
  input  logic [DW-1:0]              din_wdata,
  input  logic                       dout_re,
  output logic [DW-1:0]              dout_rdata,
  output logic                       dma_in_req,
  output logic                       dma_out_req,
  output logic                       done_flag,
  output logic                       irq,
  output logic                       cph_req,
  output logic [1:0]                 cph_op,
  output logic [((BLK_BYTES/SEG_BYTES)>1 ? $clog2(BLK_BYTES/SEG_BYTES) : 1)-1:0] cph_seg,
  output logic [2:0]                 cph_mode,
  output logic                       cph_dec,
  output logic [DW*BLK_BYTES-1:0]    cph_data,
  output logic [DW*BLK_BYTES-1:0]    cph_key,
  output logic [DW*BLK_BYTES-1:0]    cph_iv,
  output logic                       cph_abort,
  input  logic                       cph_rsp_valid,
  input  logic [DW*BLK_BYTES-1:0]    cph_rsp_data
);

  localparam int BLK_W = DW * BLK_BYTES;
  localparam int SEG_W = DW * SEG_BYTES;
  localparam int NSEG  = BLK_BYTES / SEG_BYTES;
  localparam int SGW   = (NSEG > 1) ? $clog2(NSEG) : 1;
  localparam int CW    = $clog2(BLK_BYTES + 1);

  seq_state_e       state_q;
  logic [SGW-1:0]   seg_q;
  logic [2:0]       act_mode_q;
  logic             act_dec_q;
  logic [1:0]       op_q;
  logic [BLK_W-1:0] key_q;
  logic [BLK_W-1:0] iv_q;
  logic             dma_in_q;
  logic             dma_out_q;
  logic             req_q;
  logic             abort_q;

  cmd_e             cmd;
  logic [2:0]       wmode;
  logic             wdec;
  logic             busy;
  logic             load_cmd;
  logic             start_ok;
  logic             in_block;
  logic             stream_act;
  logic             last_unit;
  logic             in_clr;
  logic             in_en;
  logic             in_full;
  logic [CW-1:0]    in_unit;
  logic [CW-1:0]    out_unit;
  logic [BLK_W-1:0] in_data;
  logic             out_load;
  logic             out_en;
  logic             out_empty;
  logic [BLK_W-1:0] out_ldata;
  logic             done_set;

  // ---------------- control / status register ----------------
  cseq_ctl_reg u_ctl (
    .clk      (clk),
    .rst      (rst),
    .we       (ctl_we),
    .wdata    (ctl_wdata),
    .done_set (done_set),
    .busy     (busy),
    .cmd      (cmd),
    .wmode    (wmode),
    .wdec     (wdec),
    .done_q   (done_flag),
    .irq_q    (irq),
    .rdata    (ctl_rdata)
  );

  // ---------------- decode ----------------
  always_comb begin
    busy       = (state_q != ST_IDLE);
    load_cmd   = (cmd == CMD_KEY) || (cmd == CMD_IV);
    start_ok   = (cmd == CMD_START) && (state_q == ST_IDLE);
    in_block   = (state_q == ST_FILL) || (state_q == ST_PROCESS) ||
                 (state_q == ST_DRAIN);
    stream_act = is_stream(act_mode_q);
    last_unit  = !stream_act || (seg_q == SGW'(NSEG - 1));
    in_en      = (state_q == ST_LOAD_KEY) || (state_q == ST_LOAD_IV) ||
                 (state_q == ST_FILL);
    in_unit    = (state_q == ST_FILL && stream_act) ? CW'(SEG_BYTES)
                                                    : CW'(BLK_BYTES);
    out_unit   = stream_act ? CW'(SEG_BYTES) : CW'(BLK_BYTES);
    out_en     = (state_q == ST_DRAIN);
    in_clr     = !pwr_down &&
                 (load_cmd || start_ok ||
                  (state_q == ST_DRAIN && out_empty && !last_unit));
    out_load   = !pwr_down && !load_cmd && (state_q == ST_PROCESS) &&
                 cph_rsp_valid;
    done_set   = out_load && last_unit;
  end

  // Segment results are moved to the top so bytes leave MSB first
  generate
    if (NSEG > 1) begin : g_seg_align
      always_comb begin
        if (stream_act)
          out_ldata = {cph_rsp_data[SEG_W-1:0], {(BLK_W-SEG_W){1'b0}}};
        else
          out_ldata = cph_rsp_data;
      end
    end else begin : g_blk_only
      always_comb out_ldata = cph_rsp_data;
    end
  endgenerate

  // ---------------- byte assembly and unload ----------------
  cseq_in_shift #(.DW(DW), .BYTES(BLK_BYTES), .CW(CW)) u_in (
    .clk  (clk),
    .rst  (rst),
    .clr  (in_clr),
    .en   (in_en),
    .we   (din_we),
    .din  (din_wdata),
    .unit (in_unit),
    .data (in_data),
    .full (in_full)
  );

  cseq_out_shift #(.DW(DW), .BYTES(BLK_BYTES), .CW(CW)) u_out (
    .clk   (clk),
    .rst   (rst),
    .load  (out_load),
    .ldata (out_ldata),
    .en    (out_en),
    .pop   (dout_re),
    .unit  (out_unit),
    .dout  (dout_rdata),
    .empty (out_empty)
  );

  // ---------------- sequencer ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      seg_q      <= '0;
      act_mode_q <= '0;
      act_dec_q  <= 1'b0;
      op_q       <= OP_BLK;
      key_q      <= '0;
      iv_q       <= '0;
      dma_in_q   <= 1'b0;
      dma_out_q  <= 1'b0;
      req_q      <= 1'b0;
      abort_q    <= 1'b0;
    end else begin
      dma_in_q  <= 1'b0;
      dma_out_q <= 1'b0;
      req_q     <= 1'b0;
      abort_q   <= 1'b0;
      if (pwr_down) begin
        state_q <= ST_IDLE;
        key_q   <= '0;
        iv_q    <= '0;
      end else if (load_cmd) begin
        state_q  <= (cmd == CMD_KEY) ? ST_LOAD_KEY : ST_LOAD_IV;
        dma_in_q <= 1'b1;
        if (in_block)
          abort_q <= 1'b1;
        if (cmd == CMD_IV)
          act_mode_q <= wmode;
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            if (cmd == CMD_START) begin
              state_q    <= ST_FILL;
              seg_q      <= '0;
              act_mode_q <= wmode;
              act_dec_q  <= wdec;
              dma_in_q   <= 1'b1;
            end
          end
          ST_LOAD_KEY: begin
            if (in_full) begin
              key_q   <= in_data;
              op_q    <= OP_KEY;
              req_q   <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
          ST_LOAD_IV: begin
            if (in_full) begin
              iv_q    <= in_data;
              op_q    <= OP_IV;
              req_q   <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
          ST_FILL: begin
            if (in_full) begin
              op_q    <= OP_BLK;
              req_q   <= 1'b1;
              state_q <= ST_PROCESS;
            end
          end
          ST_PROCESS: begin
            if (cph_rsp_valid) begin
              dma_out_q <= 1'b1;
              state_q   <= ST_DRAIN;
            end
          end
          ST_DRAIN: begin
            if (out_empty) begin
              if (last_unit) begin
                state_q <= ST_IDLE;
              end else begin
                seg_q    <= seg_q + 1'b1;
                dma_in_q <= 1'b1;
                state_q  <= ST_FILL;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign dma_in_req  = dma_in_q;
  assign dma_out_req = dma_out_q;
  assign cph_req     = req_q;
  assign cph_op      = op_q;
  assign cph_seg     = seg_q;
  assign cph_mode    = act_mode_q;
  assign cph_dec     = act_dec_q;
  assign cph_data    = in_data;
  assign cph_key     = key_q;
  assign cph_iv      = iv_q;
  assign cph_abort   = abort_q;

endmodule

// File: rtl/cipher_cmd_seq_chk.sv
module cipher_cmd_seq_chk
  import cseq_pkg::*;
#(
  parameter int BLK_W = 128,
  parameter int SEG_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             pwr_down,
  input logic             ctl_we,
  input logic [7:0]       ctl_wdata,
  input logic [7:0]       ctl_rdata,
  input logic             dma_in_req,
  input logic             dma_out_req,
  input logic             done_flag,
  input logic             irq,
  input logic             cph_req,
  input logic [1:0]       cph_op,
  input logic [2:0]       cph_mode,
  input logic [BLK_W-1:0] cph_data,
  input logic [BLK_W-1:0] cph_key,
  input logic [BLK_W-1:0] cph_iv,
  input logic             cph_abort,
  input seq_state_e       state
);

  a_r2_start_trigger: assert property (@(posedge clk) disable iff (rst)
    ctl_we && ctl_wdata[1:0] == 2'd1 && state == ST_IDLE && !pwr_down
    |=> dma_in_req && ctl_rdata[0]);

  a_r7_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
    ctl_we && ctl_wdata[1:0] == 2'd1 && !pwr_down &&
    (state == ST_FILL || state == ST_PROCESS)
    |=> !dma_in_req);

  a_r3_block_req_state: assert property (@(posedge clk) disable iff (rst)
    cph_req && cph_op == OP_BLK |-> state == ST_PROCESS);

  a_r5_segment_zero_ext: assert property (@(posedge clk) disable iff (rst)
    cph_req && cph_op == OP_BLK && is_stream(cph_mode)
    |-> cph_data[BLK_W-1:SEG_W] == '0);

  a_r4_out_trigger_pulse: assert property (@(posedge clk) disable iff (rst)
    dma_out_req |=> !dma_out_req);

  a_r6_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq |-> done_flag);

  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    done_flag && !(ctl_we && !ctl_wdata[7]) |=> done_flag);

  a_r9_abort_in_load: assert property (@(posedge clk) disable iff (rst)
    cph_abort |-> (state == ST_LOAD_KEY || state == ST_LOAD_IV));

  a_r10_power_down_clear: assert property (@(posedge clk) disable iff (rst)
    pwr_down |=> cph_key == '0 && cph_iv == '0 && state == ST_IDLE);

endmodule

bind cipher_cmd_seq cipher_cmd_seq_chk #(
  .BLK_W (DW * BLK_BYTES),
  .SEG_W (DW * SEG_BYTES)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .pwr_down    (pwr_down),
  .ctl_we      (ctl_we),
  .ctl_wdata   (ctl_wdata),
  .ctl_rdata   (ctl_rdata),
  .dma_in_req  (dma_in_req),
  .dma_out_req (dma_out_req),
  .done_flag   (done_flag),
  .irq         (irq),
  .cph_req     (cph_req),
  .cph_op      (cph_op),
  .cph_mode    (cph_mode),
  .cph_data    (cph_data),
  .cph_key     (cph_key),
  .cph_iv      (cph_iv),
  .cph_abort   (cph_abort),
  .state       (state_q)
);

// File: tb/cipher_cmd_seq_bench.sv
module cipher_cmd_seq_bench;

  logic         clk;
  logic         rst;
  logic         pwr_down;
  logic         ctl_we;
  logic [7:0]   ctl_wdata;
  logic [7:0]   ctl_rdata;
  logic         din_we;
  logic [7:0]   din_wdata;
  logic         dout_re;
  logic [7:0]   dout_rdata;
  logic         dma_in_req;
  logic         dma_out_req;
  logic         done_flag;
  logic         irq;
  logic         cph_req;
  logic [1:0]   cph_op;
  logic [1:0]   cph_seg;
  logic [2:0]   cph_mode;
  logic         cph_dec;
  logic [127:0] cph_data;
  logic [127:0] cph_key;
  logic [127:0] cph_iv;
  logic         cph_abort;
  logic         cph_rsp_valid;
  logic [127:0] cph_rsp_data;

  cipher_cmd_seq u_cipher_cmd_seq (
    .clk           (clk),
    .rst           (rst),
    .pwr_down      (pwr_down),
    .ctl_we        (ctl_we),
    .ctl_wdata     (ctl_wdata),
    .ctl_rdata     (ctl_rdata),
    .din_we        (din_we),
    .din_wdata     (din_wdata),
    .dout_re       (dout_re),
    .dout_rdata    (dout_rdata),
    .dma_in_req    (dma_in_req),
    .dma_out_req   (dma_out_req),
    .done_flag     (done_flag),
    .irq           (irq),
    .cph_req       (cph_req),
    .cph_op        (cph_op),
    .cph_seg       (cph_seg),
    .cph_mode      (cph_mode),
    .cph_dec       (cph_dec),
    .cph_data      (cph_data),
    .cph_key       (cph_key),
    .cph_iv        (cph_iv),
    .cph_abort     (cph_abort),
    .cph_rsp_valid (cph_rsp_valid),
    .cph_rsp_data  (cph_rsp_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int           n_chk = 0;
  int           n_fail = 0;
  bit           finished = 0;
  logic [127:0] exp_key = '0;
  logic [127:0] exp_iv = '0;
  bit           exp_done = 0;
  bit           exp_ie = 0;
  logic [2:0]   cur_mode = 3'd0;
  bit           cur_dec = 0;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic ceq(input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ctl_byte(input logic [1:0] cmd, input bit clr);
    return {~clr, exp_ie, cur_dec, cur_mode, cmd};
  endfunction

  task automatic ctl(input logic [1:0] cmd, input bit clr);
    ctl_we    = 1'b1;
    ctl_wdata = ctl_byte(cmd, clr);
    tick();
    ctl_we    = 1'b0;
  endtask

  task automatic din(input logic [7:0] b);
    din_we    = 1'b1;
    din_wdata = b;
    tick();
    din_we    = 1'b0;
  endtask

  function automatic bit stream_mode(input logic [2:0] m);
    return (m == 3'd2) || (m == 3'd3) || (m == 3'd4);
  endfunction

  // Stand-in datapath: a keyed scramble the bench can predict
  function automatic logic [127:0] rsp_of(input logic [127:0] x);
    return x ^ {exp_key[31:0], exp_key[127:32]} ^
           128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;
  endfunction

  task automatic load(input bit is_iv, input logic [127:0] v, input logic [2:0] mode);
    cur_mode = mode;
    ctl(is_iv ? 2'd3 : 2'd2, 1'b0);
    ceq("R8 load trigger", dma_in_req, 1);
    ceq("R8 load busy", ctl_rdata[0], 1);
    for (int i = 0; i < 16; i++) din(v[127-8*i -: 8]);
    tick();
    ceq("R8 load request", cph_req, 1);
    ceq("R8 load op", cph_op, is_iv ? 2 : 1);
    if (is_iv) begin
      ceq("R8 iv value", cph_iv, v);
      ceq("R8 iv mode", cph_mode, mode);
      exp_iv = v;
    end else begin
      ceq("R8 key value", cph_key, v);
      exp_key = v;
    end
    ceq("R8 back to idle", ctl_rdata[0], 0);
  endtask

  // inj[0]: start during fill; inj[1]: flag clear on the response edge;
  // inj[2]: stray data-in write and data-out read while a request is pending
  task automatic run_block(input logic [2:0] mode, input bit dec,
                           input logic [127:0] data, input bit [2:0] inj);
    bit           strm;
    int           nseg;
    int           ub;
    logic [127:0] unit;
    logic [127:0] rsp;
    logic [127:0] outexp;
    cur_mode = mode;
    cur_dec  = dec;
    strm = stream_mode(mode);
    nseg = strm ? 4 : 1;
    ub   = strm ? 4 : 16;
    ctl(2'd1, 1'b0);
    for (int s = 0; s < nseg; s++) begin
      if (s == 0) ceq("R2 start trigger", dma_in_req, 1);
      else        ceq("R5 segment trigger", dma_in_req, 1);
      ceq("R2 busy", ctl_rdata[0], 1);
      unit = strm ? {96'b0, data[127-32*s -: 32]} : data;
      for (int i = 0; i < ub; i++) begin
        din(unit[8*ub-1-8*i -: 8]);
        if (inj[0] && i == 1) begin
          ctl(2'd1, 1'b0);
          ceq("R7 start while busy", dma_in_req, 0);
        end
      end
      tick();
      ceq("R3 request", cph_req, 1);
      ceq("R3 op", cph_op, 0);
      ceq("R3 data", cph_data, unit);
      ceq("R5 segment index", cph_seg, s);
      ceq("R2 mode", cph_mode, mode);
      ceq("R2 direction", cph_dec, dec);
      if (inj[2]) begin
        din(8'hEE);
        ceq("R11 data-in ignored", cph_data, unit);
        dout_re = 1'b1;
        tick();
        dout_re = 1'b0;
      end
      repeat ($urandom_range(0, 3)) tick();
      rsp = rsp_of(unit);
      cph_rsp_valid = 1'b1;
      cph_rsp_data  = rsp;
      if (inj[1]) begin
        ctl_we    = 1'b1;
        ctl_wdata = ctl_byte(2'd0, 1'b1);
      end
      tick();
      cph_rsp_valid = 1'b0;
      ctl_we        = 1'b0;
      if (s == nseg - 1) exp_done = 1;
      else if (inj[1])   exp_done = 0;
      ceq("R4 output trigger", dma_out_req, 1);
      ceq("R6 flag", done_flag, exp_done);
      ceq("R6 irq", irq, exp_done & exp_ie);
      outexp = strm ? {rsp[31:0], 96'b0} : rsp;
      for (int i = 0; i < ub; i++) begin
        if (strm) ceq("R5 segment byte", dout_rdata, outexp[127-8*i -: 8]);
        else      ceq("R4 block byte", dout_rdata, outexp[127-8*i -: 8]);
        dout_re = 1'b1;
        tick();
        dout_re = 1'b0;
      end
      tick();
    end
    ceq("R4 idle after drain", ctl_rdata[0], 0);
    ceq("R6 status flag", ctl_rdata[7], exp_done);
  endtask

  initial begin
    logic [127:0] k2;
    int seed;
    seed = $urandom(32'd2024);
    rst = 1'b1; pwr_down = 0; ctl_we = 0; ctl_wdata = 0; din_we = 0;
    din_wdata = 0; dout_re = 0; cph_rsp_valid = 0; cph_rsp_data = '0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    ceq("R1 status", ctl_rdata, 0);
    ceq("R1 key", cph_key, 0);
    ceq("R1 iv", cph_iv, 0);
    ceq("R1 strobes", {dma_in_req, dma_out_req, cph_req, cph_abort, irq}, 0);

    load(1'b0, 128'h00112233_44556677_8899AABB_CCDDEEFF, 3'd0);
    load(1'b1, 128'hF0E1D2C3_B4A59687_78695A4B_3C2D1E0F, 3'd1);

    exp_ie = 1;
    run_block(3'd0, 1'b0, 128'h01020304_05060708_090A0B0C_0D0E0F10, 3'b000);
    ctl(2'd0, 1'b1);
    exp_done = 0;
    ceq("R6 cleared", done_flag, 0);
    ceq("R6 irq cleared", irq, 0);
    run_block(3'd1, 1'b1, 128'hCAFEF00D_DEADBEEF_13579BDF_2468ACE0, 3'b111);
    ctl(2'd0, 1'b1);
    exp_done = 0;
    run_block(3'd4, 1'b0, 128'h11111111_22222222_33333333_44444444, 3'b011);
    exp_ie = 0;
    run_block(3'd2, 1'b1, 128'hA1B2C3D4_E5F60718_293A4B5C_6D7E8F90, 3'b100);

    // Abort: a key command with a request pending drops the response
    ctl(2'd0, 1'b1);
    exp_done = 0;
    cur_mode = 3'd0;
    ctl(2'd1, 1'b0);
    for (int i = 0; i < 16; i++) din(8'(i * 17));
    tick();
    ceq("R9 request pending", cph_req, 1);
    ctl(2'd2, 1'b0);
    ceq("R9 abort pulse", cph_abort, 1);
    ceq("R9 reload trigger", dma_in_req, 1);
    cph_rsp_valid = 1'b1;
    cph_rsp_data  = '1;
    tick();
    cph_rsp_valid = 1'b0;
    ceq("R9 no output trigger", dma_out_req, 0);
    ceq("R9 no flag", done_flag, 0);
    k2 = 128'h5A5A5A5A_C3C3C3C3_0F0F0F0F_96969696;
    for (int i = 0; i < 16; i++) din(k2[127-8*i -: 8]);
    tick();
    ceq("R9 key after abort", cph_key, k2);
    exp_key = k2;
    tick();

    // Power-down clears key and IV and stops a block
    pwr_down = 1'b1;
    tick();
    pwr_down = 1'b0;
    ceq("R10 key cleared", cph_key, 0);
    ceq("R10 iv cleared", cph_iv, 0);
    exp_key = '0;
    ctl(2'd1, 1'b0);
    din(8'h12);
    din(8'h34);
    pwr_down = 1'b1;
    tick();
    pwr_down = 1'b0;
    ceq("R10 idle after power-down", ctl_rdata[0], 0);
    dout_re = 1'b1;
    tick();
    dout_re = 1'b0;
    ceq("R11 read in idle", dout_rdata, 0);

    load(1'b0, {$urandom, $urandom, $urandom, $urandom}, 3'd0);
    for (int n = 0; n < 8; n++) begin
      exp_ie = bit'($urandom_range(0, 1));
      run_block(3'($urandom_range(0, 5)), bit'($urandom_range(0, 1)),
                {$urandom, $urandom, $urandom, $urandom},
                3'($urandom_range(0, 7)));
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule